// File: doc/BRIEF.md
# Streaming Forward 9/7 Integer Lifting Wavelet (One Dimension)

This block applies one level of the forward integer 9/7 wavelet to a stream of signed image samples that arrive one line at a time. Each line enters as a sequence of samples. The first sample carries a start marker and the last sample carries an end marker. The block returns the same number of coefficients in interleaved order: low-pass s[0], high-pass d[0], low-pass s[1], high-pass d[1], and so on. Every value is an integer. The computation uses a predict lifting step and an update lifting step. At both ends of a line, missing neighbours come from whole-sample mirroring, so the block needs no more than a few samples of storage.

The lifting arithmetic has four register levels inserted into it. No path between two registers passes through more than one adder. The register placement changes only the timing and never the arithmetic result. Lines must have an even length of at least 8 samples. When a line ends, the block generates two internal extension steps itself. During those steps it holds in_ready low for four cycles.

Both stream edges use valid/ready. An input sample is taken on a clock edge where in_valid and in_ready are both high. An output coefficient is taken on an edge where out_valid and out_ready are both high. If out_ready is low while out_valid is high, the whole datapath freezes: the presented coefficient stays unchanged and in_ready goes low in the same cycle. The producer may leave gaps in its valid at any time.

Top module: `lift97_fwd`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is low and in_ready is high.
- R2: The high-pass output is d[n] = x[2n+1] - floor((9*(x[2n]+x[2n+2]) - (x[2n-2]+x[2n+4]) + 8) / 16).
- R3: The low-pass output is s[n] = x[2n] - floor((2 - (d[n-1]+d[n])) / 4).
- R4: Outside the line, samples are mirrored about the end samples without repeating them: x[-i] = x[i] and x[N-1+i] = x[N-1-i]. The same mirroring gives d[-1] = d[0].
- R5: Coefficients leave in the order s[0], d[0], s[1], d[1], and so on. out_high is 0 for a low-pass value and 1 for a high-pass value. When a low-pass value is taken, the high-pass value with the same index is presented on the next cycle.
- R6: out_first is high only with s[0] of a line, and out_last is high only with d[N/2-1] of a line.
- R7: While out_valid is high and out_ready is low, out_data and the flags stay unchanged. No coefficient is lost or duplicated, whatever pattern of stalls the consumer applies.
- R8: If the output is not stalled, in_ready is low for exactly the four cycles after the edge that takes the last sample of a line, and high in the cycle after those.
- R9: If the output is not stalled, s[0] is presented (out_valid high with out_first) on the fifth rising edge after the edge that takes x[5].
- R10: out_data is a two's-complement value W+2 bits wide. Lines of all-maximum, all-minimum or alternating extreme samples give exact results, with no wrap-around.
- R11: Gaps in in_valid have no effect on the coefficient values or their order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_data holds a sample |
| in_ready | output | 1 | Block takes a sample on this edge |
| in_data | input | W | Signed input sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_eol | input | 1 | Sample is the last of a line |
| out_valid | output | 1 | out_data holds a coefficient |
| out_ready | input | 1 | Consumer takes the coefficient on this edge |
| out_data | output | W+2 | Signed coefficient |
| out_high | output | 1 | 1 for high-pass, 0 for low-pass |
| out_first | output | 1 | First coefficient of a line |
| out_last | output | 1 | Last coefficient of a line |

## Verification
The hardest state to reach is a consumer stall that arrives while the block is producing the two end-of-line extension steps, with the next line already waiting at the input. On 8-sample lines the extensions at the start and the end fall on neighbouring steps, which makes this worse. To get there, the stimulus mixes many short lines with random drops of out_ready and random input gaps. Directed lines with extreme sample values and an impulse fix the boundary results. A first stretch with no stalls measures the end-of-line gap in in_ready and the fixed latency.

// File: rtl/lift97_pkg.sv
package lift97_pkg;
  // Extra bits carried by the output coefficient over the sample width
  localparam int unsigned OUT_GROWTH = 2;
  // Extra bits carried by the internal lifting arithmetic
  localparam int unsigned ACC_GROWTH = 6;

  typedef struct packed {
    logic first;  // step produces index 0 of a line
    logic last;   // step produces the final index of a line
  } mark_t;
endpackage

// File: rtl/lift97_framer.sv
// Collects samples into even/odd pairs, keeps a short history of evens and
// odds, and issues one lifting step per pair, with mirrored operands at the
// line start and two self-generated steps after the line end.
module lift97_framer
  import lift97_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_data,
  input  logic                in_sol,
  input  logic                in_eol,
  output logic                step_v,
  output logic signed [W-1:0] st_em1,
  output logic signed [W-1:0] st_e0,
  output logic signed [W-1:0] st_e1,
  output logic signed [W-1:0] st_e2,
  output logic signed [W-1:0] st_o,
  output mark_t               st_mark
);
  localparam logic [2:0] FLUSH_LEN = 3'd4;

  logic signed [W-1:0] even_q, h1, h2, h3, oh1, oh2;
  logic                even_sol, phase;
  logic [1:0]          kcnt;
  logic [2:0]          fc;
  logic                acc;
  logic [1:0]          pidx;

  assign in_ready = adv && (fc == 3'd0);
  assign acc      = in_valid && in_ready;
  assign pidx     = even_sol ? 2'd0 : kcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q <= '0; even_sol <= 1'b0; phase <= 1'b0; kcnt <= 2'd0; fc <= 3'd0;
      h1 <= '0; h2 <= '0; h3 <= '0; oh1 <= '0; oh2 <= '0;
      step_v <= 1'b0; st_em1 <= '0; st_e0 <= '0; st_e1 <= '0; st_e2 <= '0;
      st_o <= '0; st_mark <= '0;
    end else if (adv) begin
      step_v <= 1'b0;
      if (fc != 3'd0) fc <= fc - 3'd1;
      if (acc) begin
        if (in_sol || !phase) begin
          even_q   <= in_data;
          even_sol <= in_sol;
          phase    <= 1'b1;
        end else begin
          phase <= 1'b0;
          h3 <= h2; h2 <= h1; h1 <= even_q;
          oh2 <= oh1; oh1 <= in_data;
          kcnt <= (pidx == 2'd3) ? 2'd3 : pidx + 2'd1;
          if (pidx >= 2'd2) begin
            step_v        <= 1'b1;
            st_em1        <= (pidx == 2'd2) ? h1 : h3;  // left mirror on index 0
            st_e0         <= h2;
            st_e1         <= h1;
            st_e2         <= even_q;
            st_o          <= oh2;
            st_mark.first <= (pidx == 2'd2);
            st_mark.last  <= 1'b0;
            if (in_eol) fc <= FLUSH_LEN;
          end
        end
      end else if (fc == 3'd3) begin
        // first extension step: next even equals the last real even
        step_v  <= 1'b1;
        st_em1  <= h3; st_e0 <= h2; st_e1 <= h1; st_e2 <= h1; st_o <= oh2;
        st_mark <= '0;
        h3 <= h2; h2 <= h1; oh2 <= oh1;
      end else if (fc == 3'd1) begin
        // second extension step: mirrored even two places back
        step_v        <= 1'b1;
        st_em1        <= h3; st_e0 <= h2; st_e1 <= h1; st_e2 <= h3; st_o <= oh2;
        st_mark.first <= 1'b0;
        st_mark.last  <= 1'b1;
        phase         <= 1'b0;
      end
    end
  end

  // R8: taking the closing pair of a line starts the input gap at once
  p_flush_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase && !in_sol && in_eol && pidx >= 2'd2) |=> !in_ready);
endmodule

// File: rtl/lift97_lift.sv
// Predict and update arithmetic, split by four register levels so that each
// register-to-register segment holds a single adder.
module lift97_lift
  import lift97_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned NW = W + ACC_GROWTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 step_v,
  input  logic signed [W-1:0]  st_em1,
  input  logic signed [W-1:0]  st_e0,
  input  logic signed [W-1:0]  st_e1,
  input  logic signed [W-1:0]  st_e2,
  input  logic signed [W-1:0]  st_o,
  input  mark_t                st_mark,
  output logic                 res_v,
  output logic signed [NW-1:0] res_s,
  output logic signed [NW-1:0] res_d,
  output mark_t                res_mark
);
  function automatic logic signed [NW-1:0] sx(input logic signed [W-1:0] v);
    return {{(NW-W){v[W-1]}}, v};
  endfunction

  // level 1: pair sums
  logic                 v1;
  logic signed [NW-1:0] a1, r1;
  logic signed [W-1:0]  o1, e0_1;
  mark_t                mk1;
  // level 2: nine times inner sum, scaled odd plus outer sum
  logic                 v2;
  logic signed [NW-1:0] a9_2, u2;
  logic signed [W-1:0]  e0_2;
  mark_t                mk2;
  // level 3: high-pass value
  logic                 v3;
  logic signed [NW-1:0] d3, dprev;
  logic signed [W-1:0]  e0_3;
  mark_t                mk3;
  // level 4: sum of neighbouring high-pass values
  logic                 v4;
  logic signed [NW-1:0] w4, d4;
  logic signed [W-1:0]  e0_4;
  mark_t                mk4;

  logic signed [NW-1:0] pw, dsel, e4q;

  // 16*odd + 7: rounding offset placed in the zero low bits
  assign pw   = {{(NW-W-4){o1[W-1]}}, o1, 4'b0111};
  assign dsel = mk3.first ? d3 : dprev;
  // 4*even + 1: rounding offset placed in the zero low bits
  assign e4q  = {{(NW-W-2){e0_4[W-1]}}, e0_4, 2'b01};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
      a1 <= '0; r1 <= '0; o1 <= '0; e0_1 <= '0; mk1 <= '0;
      a9_2 <= '0; u2 <= '0; e0_2 <= '0; mk2 <= '0;
      d3 <= '0; dprev <= '0; e0_3 <= '0; mk3 <= '0;
      w4 <= '0; d4 <= '0; e0_4 <= '0; mk4 <= '0;
    end else if (adv) begin
      v1 <= step_v; v2 <= v1; v3 <= v2; v4 <= v3;
      a1   <= sx(st_e0) + sx(st_e1);
      r1   <= sx(st_em1) + sx(st_e2);
      o1   <= st_o;
      e0_1 <= st_e0;
      mk1  <= st_mark;
      a9_2 <= (a1 <<< 3) + a1;
      u2   <= pw + r1;
      e0_2 <= e0_1;
      mk2  <= mk1;
      d3   <= (u2 - a9_2) >>> 4;
      e0_3 <= e0_2;
      mk3  <= mk2;
      if (v3) dprev <= d3;
      w4   <= d3 + dsel;
      d4   <= d3;
      e0_4 <= e0_3;
      mk4  <= mk3;
    end
  end

  assign res_v    = v4;
  assign res_d    = d4;
  assign res_s    = (e4q + w4) >>> 2;
  assign res_mark = mk4;
endmodule

// File: rtl/lift97_serial.sv
// Turns each (low, high) result pair into two consecutive output beats.
module lift97_serial
  import lift97_pkg::*;
#(
  parameter int unsigned OW = 14,
  parameter int unsigned NW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 res_v,
  input  logic signed [NW-1:0] res_s,
  input  logic signed [NW-1:0] res_d,
  input  mark_t                res_mark,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data,
  output logic                 out_high,
  output logic                 out_first,
  output logic                 out_last
);
  logic signed [OW-1:0] pend;
  logic                 pend_v, pend_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_high <= 1'b0;
      out_first <= 1'b0; out_last <= 1'b0;
      pend <= '0; pend_v <= 1'b0; pend_last <= 1'b0;
    end else if (adv) begin
      if (res_v) begin
        out_valid <= 1'b1;
        out_data  <= res_s[OW-1:0];
        out_high  <= 1'b0;
        out_first <= res_mark.first;
        out_last  <= 1'b0;
        pend      <= res_d[OW-1:0];
        pend_v    <= 1'b1;
        pend_last <= res_mark.last;
      end else if (pend_v) begin
        out_valid <= 1'b1;
        out_data  <= pend;
        out_high  <= 1'b1;
        out_first <= 1'b0;
        out_last  <= pend_last;
        pend_v    <= 1'b0;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10: both results fit the output width before truncation
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_v |-> (((&res_s[NW-1:OW-1]) || !(|res_s[NW-1:OW-1])) &&
               ((&res_d[NW-1:OW-1]) || !(|res_d[NW-1:OW-1]))));
  // R5: a new result pair never meets an unsent high-pass value
  p_slot_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_v |-> !pend_v);
  // R6: line markers sit on the right band
  p_first_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> !out_high);
  p_last_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_high);
endmodule

// File: rtl/lift97_fwd.sv
module lift97_fwd
  import lift97_pkg::*;
#(
  parameter int unsigned W  = 12,
  localparam int unsigned OW = W + OUT_GROWTH,
  localparam int unsigned NW = W + ACC_GROWTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [W-1:0]  in_data,
  input  logic                 in_sol,
  input  logic                 in_eol,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_data,
  output logic                 out_high,
  output logic                 out_first,
  output logic                 out_last
);
  logic                 adv;
  logic                 step_v, res_v;
  logic signed [W-1:0]  st_em1, st_e0, st_e1, st_e2, st_o;
  mark_t                st_mark, res_mark;
  logic signed [NW-1:0] res_s, res_d;

  // whole datapath moves only when the output slot can change
  assign adv = !out_valid || out_ready;

  lift97_framer #(.W(W)) u_framer (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sol(in_sol), .in_eol(in_eol),
    .step_v(step_v), .st_em1(st_em1), .st_e0(st_e0), .st_e1(st_e1),
    .st_e2(st_e2), .st_o(st_o), .st_mark(st_mark)
  );

  lift97_lift #(.W(W), .NW(NW)) u_lift (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .step_v(step_v), .st_em1(st_em1), .st_e0(st_e0), .st_e1(st_e1),
    .st_e2(st_e2), .st_o(st_o), .st_mark(st_mark),
    .res_v(res_v), .res_s(res_s), .res_d(res_d), .res_mark(res_mark)
  );

  lift97_serial #(.OW(OW), .NW(NW)) u_serial (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .res_v(res_v), .res_s(res_s), .res_d(res_d), .res_mark(res_mark),
    .out_valid(out_valid), .out_data(out_data), .out_high(out_high),
    .out_first(out_first), .out_last(out_last)
  );

  // R7: a stalled coefficient is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_high) && $stable(out_first) && $stable(out_last)));
  // R5: the high-pass partner follows a taken low-pass value
  p_partner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_high) |=> (out_valid && out_high));
endmodule

// File: tb/tb_lift97_fwd.sv
module tb_lift97_fwd;
  localparam int W    = 12;
  localparam int OW   = W + 2;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));
  localparam int CAP  = 4096;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [W-1:0]  in_data = '0;
  logic                 in_sol = 1'b0;
  logic                 in_eol = 1'b0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic signed [OW-1:0] out_data;
  logic                 out_high, out_first, out_last;

  lift97_fwd #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_high(out_high), .out_first(out_first), .out_last(out_last)
  );

  always #10 clk = ~clk;  // 50 MHz

  int edges = 0;
  bit timeout = 1'b0;
  always @(posedge clk) begin
    edges <= edges + 1;
    if (edges > 150000) timeout <= 1'b1;
  end

  int n_tests = 0, n_fail = 0;

  int sdat[CAP]; bit ssol[CAP]; bit seol[CAP]; int ns = 0;
  int edat[CAP]; bit ehigh[CAP]; bit efirst[CAP]; bit elast[CAP];
  bit ebnd[CAP]; bit eext[CAP]; int ne = 0;

  function automatic int mx(int i, int n);
    if (i < 0) i = -i;
    if (i >= n) i = 2*n - 2 - i;
    return i;
  endfunction

  task automatic add_line(input int n, input int kind, input bit ext);
    int xl[128];
    int dl[64];
    int m = n / 2;
    for (int i = 0; i < n; i++) begin
      case (kind)
        1: xl[i] = MAXV;
        2: xl[i] = MINV;
        3: xl[i] = (i % 2) ? MINV : MAXV;
        4: xl[i] = (i % 2) ? MAXV : MINV;
        5: xl[i] = i * 37 - 150;
        6: xl[i] = (i == 3) ? MAXV : 0;
        default: xl[i] = int'($urandom % (1 << W)) + MINV;
      endcase
      sdat[ns] = xl[i]; ssol[ns] = (i == 0); seol[ns] = (i == n-1); ns++;
    end
    for (int k = 0; k < m; k++)
      dl[k] = xl[2*k+1] - ((9*(xl[mx(2*k,n)] + xl[mx(2*k+2,n)])
              - (xl[mx(2*k-2,n)] + xl[mx(2*k+4,n)]) + 8) >>> 4);
    for (int k = 0; k < m; k++) begin
      int dm = (k == 0) ? dl[0] : dl[k-1];
      edat[ne] = xl[2*k] - ((2 - (dm + dl[k])) >>> 2);
      ehigh[ne] = 1'b0; efirst[ne] = (k == 0); elast[ne] = 1'b0;
      ebnd[ne] = (k == 0 || k == m-1); eext[ne] = ext; ne++;
      edat[ne] = dl[k];
      ehigh[ne] = 1'b1; efirst[ne] = 1'b0; elast[ne] = (k == m-1);
      ebnd[ne] = (k == 0 || k == m-1); eext[ne] = ext; ne++;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    int si = 0, oi = 0;
    int lat_start = -1;
    bit lat_done = 1'b0;
    int fw = 0;
    int unsigned seed;
    seed = $urandom(32'h1A7E5);
    // directed lines first: two without stalls, then corners
    add_line(8, 5, 1'b0);
    add_line(8, 0, 1'b0);
    add_line(8, 1, 1'b1);
    add_line(8, 2, 1'b1);
    add_line(10, 3, 1'b1);
    add_line(8, 4, 1'b1);
    add_line(12, 6, 1'b0);
    for (int l = 0; l < 30; l++) add_line(8 + 2 * int'($urandom % 29), 0, 1'b0);

    repeat (3) @(negedge clk);
    // R1: during reset
    check(!out_valid && in_ready, "R1 during reset out_valid/in_ready",
          {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset out_valid/in_ready",
          {out_valid, in_ready}, 1);

    while (oi < ne && !timeout) begin
      bit nostall;
      @(negedge clk);
      nostall = (oi < 16);
      if (si < ns && (nostall || ($urandom % 4) != 0)) begin
        in_valid = 1'b1; in_data = W'(sdat[si]); in_sol = ssol[si]; in_eol = seol[si];
      end else begin
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
      end
      out_ready = nostall ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (fw > 0) begin
        if (fw > 1) check(!in_ready, "R8 in_ready during end-of-line gap", in_ready, 0);
        else        check(in_ready,  "R8 in_ready after end-of-line gap", in_ready, 1);
        fw--;
      end
      if (out_valid && out_first && !lat_done && lat_start >= 0) begin
        check(edges - lat_start == 5, "R9 latency from x[5] to s[0]", edges - lat_start, 5);
        lat_done = 1'b1;
      end
      if (out_valid && out_ready) begin
        string tag;
        tag = ehigh[oi] ? "R2" : "R3";
        if (ebnd[oi]) tag = {tag, " R4"};
        if (eext[oi]) tag = {tag, " R10"};
        if (!nostall) tag = {tag, " R7 R11"};
        check(int'(out_data) == edat[oi], $sformatf("%s coeff %0d", tag, oi),
              int'(out_data), edat[oi]);
        check({out_high, out_first, out_last} == {ehigh[oi], efirst[oi], elast[oi]},
              $sformatf("R5 R6 flags high/first/last coeff %0d", oi),
              {out_high, out_first, out_last}, {ehigh[oi], efirst[oi], elast[oi]});
        oi++;
      end
      if (in_valid && in_ready) begin
        if (si == 5) lat_start = edges + 1;
        if (si == 7) fw = 5;
        si++;
      end
    end
    if (timeout) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", oi, ne);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule